// File: doc/BRIEF.md
# Stream Delimiter Carrier Sense Detector

This block takes aligned 5-bit code groups in a 100 Mbps receive path, one per symbol clock, and produces the media-independent receive signals: carrier sense, receive data valid, receive error and a 4-bit receive nibble. It searches idle line traffic for the start-of-stream pair, which is J then K. Once that pair is found it raises carrier and translates each following data code group into its nibble. It watches for the end-of-stream pair, which is T then R. A stream can also end abnormally, when idle, or anything else after T other than R, arrives instead of the proper end pair. Carrier then drops at once and a one-clock receive error marks the drop.

A J that is not followed by K is reported as a false carrier on a separate flag, and carrier does not rise. After a normal end, carrier is held for a parameterised number of extra symbols, so it takes longer to fall than to rise. A MAC that uses carrier to time the interframe gap will therefore see a gap slightly shorter than the one on the wire. Code-group alignment, descrambling and line decoding are done upstream.

Top module: `stream_delim_cs`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, crs, rx_dv, rx_er, false_carrier and rxd are all zero, and the block is hunting for a new start pair.
- R2: When a valid J (11000) is immediately followed by a valid K (10001), crs rises at the clock edge that samples K. In that same cycle rx_dv is 1 and rxd carries the preamble nibble 0101.
- R3: Inside a stream, each data code group drives rx_dv=1 and rxd to its nibble at the edge that samples it. The codes for nibbles 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101.
- R4: A T (01101) inside a stream drops rx_dv and zeroes rxd, with crs still high. If R (00111) follows, crs stays high for a further CRS_TAIL valid symbols, with a default of 1, and then falls, with no rx_er.
- R5: Idle (11111) inside a stream, or any code other than R right after T, drops crs and rx_dv at that edge and raises rx_er for exactly that one clock.
- R6: Any other non-data code inside a stream raises rx_er for that symbol only. Such codes include 00000, a stray J, K or R, and any code that is not a data code. In that cycle rx_dv stays 1, rxd is 0000 and crs stays high.
- R7: A valid J followed by any valid code other than K raises false_carrier for one clock and leaves crs low. The block returns to hunting, and the second symbol is discarded, even when it is itself a J.
- R8: In a clock where cg_valid is low, crs, rx_dv and rxd keep their values, rx_er and false_carrier are 0, and the stream state does not advance.
- R9: rxd is 0000 whenever rx_dv is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cg_valid | input | 1 | Strobe: cg_data holds a new aligned code group |
| cg_data | input | 5 | Aligned 5-bit code group |
| crs | output | 1 | Carrier sense |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error, one-clock pulse per event |
| rxd | output | 4 | Receive nibble |
| false_carrier | output | 1 | One-clock pulse for a J not followed by K |

## Verification
The hardest situations to reach are the ones where two delimiter rules meet. Examples are a T followed by idle instead of R, a new start pair arriving while the carrier tail from the previous stream is still running, and a gap in the valid strobe falling between the two halves of a delimiter pair. Directed sequences build each of these explicitly. A long run of random frames then mixes strobe gaps, bad codes and all three ending styles at random positions. A behavioural reference model in the bench predicts every output on every clock.

// File: rtl/sdcs_pkg.sv
package sdcs_pkg;

   localparam logic [4:0] CODE_J    = 5'b11000;
   localparam logic [4:0] CODE_K    = 5'b10001;
   localparam logic [4:0] CODE_T    = 5'b01101;
   localparam logic [4:0] CODE_R    = 5'b00111;
   localparam logic [4:0] CODE_IDLE = 5'b11111;
   localparam logic [3:0] PREAMBLE_NIB = 4'b0101;

   // classification of one received code group
   typedef enum logic [2:0] {
      CG_DATA, CG_J, CG_K, CG_T, CG_R, CG_IDLE, CG_BAD
   } cg_class_e;

   // receive stream state
   typedef enum logic [1:0] {
      ST_HUNT, ST_HALF_SSD, ST_FRAME, ST_HALF_ESD
   } rx_state_e;

   // 5-bit line code that carries a given data nibble
   function automatic logic [4:0] data_code(input logic [3:0] nib);
      logic [4:0] c;
      case (nib)
         4'h0: c = 5'b11110;
         4'h1: c = 5'b01001;
         4'h2: c = 5'b10100;
         4'h3: c = 5'b10101;
         4'h4: c = 5'b01010;
         4'h5: c = 5'b01011;
         4'h6: c = 5'b01110;
         4'h7: c = 5'b01111;
         4'h8: c = 5'b10010;
         4'h9: c = 5'b10011;
         4'hA: c = 5'b10110;
         4'hB: c = 5'b10111;
         4'hC: c = 5'b11010;
         4'hD: c = 5'b11011;
         4'hE: c = 5'b11100;
         default: c = 5'b11101;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/sdcs_cg_decode.sv
module sdcs_cg_decode
   import sdcs_pkg::*;
#(
   parameter int CG_WIDTH  = 5,
   parameter int NIB_WIDTH = 4
) (
   input  logic [CG_WIDTH-1:0]  code,
   output cg_class_e            cls,
   output logic [NIB_WIDTH-1:0] nib
);

   localparam int NUM_DATA = 1 << NIB_WIDTH;

   always_comb begin
      cls = CG_BAD;
      nib = '0;
      // data codes: search the sixteen-entry code space
      for (int i = 0; i < NUM_DATA; i++) begin
         if (code == data_code(4'(i))) begin
            cls = CG_DATA;
            nib = NIB_WIDTH'(i);
         end
      end
      // control codes never collide with data codes
      unique case (code)
         CODE_J:    cls = CG_J;
         CODE_K:    cls = CG_K;
         CODE_T:    cls = CG_T;
         CODE_R:    cls = CG_R;
         CODE_IDLE: cls = CG_IDLE;
         default:   ;
      endcase
   end

endmodule

// File: rtl/sdcs_frame_fsm.sv
module sdcs_frame_fsm
   import sdcs_pkg::*;
#(
   parameter int NIB_WIDTH = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 valid,
   input  cg_class_e            cls,
   input  logic [NIB_WIDTH-1:0] nib,
   output logic                 stream_crs,
   output logic                 dv,
   output logic [NIB_WIDTH-1:0] data,
   output logic                 err,
   output logic                 false_cs,
   output logic                 tail_load,
   output logic                 tail_clear
);

   rx_state_e state;

   // side signals for the carrier-tail counter
   assign tail_load  = valid && (state == ST_HALF_ESD) && (cls == CG_R);
   assign tail_clear = valid && (state == ST_HALF_SSD) && (cls == CG_K);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_HUNT;
         stream_crs <= 1'b0;
         dv         <= 1'b0;
         data       <= '0;
         err        <= 1'b0;
         false_cs   <= 1'b0;
      end else begin
         err      <= 1'b0;
         false_cs <= 1'b0;
         if (valid) begin
            unique case (state)
               ST_HUNT: begin
                  if (cls == CG_J) state <= ST_HALF_SSD;
               end
               ST_HALF_SSD: begin
                  if (cls == CG_K) begin
                     state      <= ST_FRAME;
                     stream_crs <= 1'b1;
                     dv         <= 1'b1;
                     data       <= NIB_WIDTH'(PREAMBLE_NIB);
                  end else begin
                     state    <= ST_HUNT;
                     false_cs <= 1'b1;
                  end
               end
               ST_FRAME: begin
                  unique case (cls)
                     CG_DATA: begin
                        dv   <= 1'b1;
                        data <= nib;
                     end
                     CG_T: begin
                        state <= ST_HALF_ESD;
                        dv    <= 1'b0;
                        data  <= '0;
                     end
                     CG_IDLE: begin
                        state      <= ST_HUNT;
                        stream_crs <= 1'b0;
                        dv         <= 1'b0;
                        data       <= '0;
                        err        <= 1'b1;
                     end
                     default: begin
                        dv   <= 1'b1;
                        data <= '0;
                        err  <= 1'b1;
                     end
                  endcase
               end
               default: begin
                  // ST_HALF_ESD
                  state      <= ST_HUNT;
                  stream_crs <= 1'b0;
                  if (cls != CG_R) err <= 1'b1;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/sdcs_crs_tail.sv
module sdcs_crs_tail #(
   parameter int CRS_TAIL = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic load,
   input  logic clear,
   output logic hold
);

   localparam int TAIL_W = (CRS_TAIL < 1) ? 1 : $clog2(CRS_TAIL + 1);

   generate
      if (CRS_TAIL == 0) begin : g_no_tail
         logic unused_tail_inputs;
         assign unused_tail_inputs = ^{clk, rst_n, step, load, clear};
         assign hold = 1'b0;
      end else begin : g_tail
         logic [TAIL_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (load) begin
               cnt <= TAIL_W'(CRS_TAIL);
            end else if (clear) begin
               cnt <= '0;
            end else if (step && (cnt != '0)) begin
               cnt <= cnt - 1'b1;
            end
         end
         assign hold = (cnt != '0);
      end
   endgenerate

endmodule

// File: rtl/stream_delim_cs.sv
module stream_delim_cs
   import sdcs_pkg::*;
#(
   parameter int CG_WIDTH  = 5,
   parameter int NIB_WIDTH = 4,
   parameter int CRS_TAIL  = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cg_valid,
   input  logic [CG_WIDTH-1:0]  cg_data,
   output logic                 crs,
   output logic                 rx_dv,
   output logic                 rx_er,
   output logic [NIB_WIDTH-1:0] rxd,
   output logic                 false_carrier
);

   generate
      if (CG_WIDTH != 5) begin : g_bad_cg_width
         $error("stream_delim_cs: CG_WIDTH must be 5");
      end
      if (NIB_WIDTH != 4) begin : g_bad_nib_width
         $error("stream_delim_cs: NIB_WIDTH must be 4");
      end
      if (CRS_TAIL < 0) begin : g_bad_tail
         $error("stream_delim_cs: CRS_TAIL must not be negative");
      end
   endgenerate

   cg_class_e            cls;
   logic [NIB_WIDTH-1:0] nib;
   logic                 stream_crs;
   logic                 tail_load;
   logic                 tail_clear;
   logic                 tail_hold;

   sdcs_cg_decode #(
      .CG_WIDTH  (CG_WIDTH),
      .NIB_WIDTH (NIB_WIDTH)
   ) u_decode (
      .code (cg_data),
      .cls  (cls),
      .nib  (nib)
   );

   sdcs_frame_fsm #(
      .NIB_WIDTH (NIB_WIDTH)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid      (cg_valid),
      .cls        (cls),
      .nib        (nib),
      .stream_crs (stream_crs),
      .dv         (rx_dv),
      .data       (rxd),
      .err        (rx_er),
      .false_cs   (false_carrier),
      .tail_load  (tail_load),
      .tail_clear (tail_clear)
   );

   sdcs_crs_tail #(
      .CRS_TAIL (CRS_TAIL)
   ) u_tail (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (cg_valid),
      .load  (tail_load),
      .clear (tail_clear),
      .hold  (tail_hold)
   );

   assign crs = stream_crs | tail_hold;

endmodule

// File: rtl/sdcs_checker.sv
module sdcs_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cg_valid,
   input logic [4:0] cg_data,
   input logic       crs,
   input logic       rx_dv,
   input logic       rx_er,
   input logic [3:0] rxd,
   input logic       false_carrier
);

   // rxd is quiet outside valid data
   assert_rxd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_dv |-> (rxd == 4'b0000));

   // carrier only rises on a K sampled one edge earlier, with preamble
   assert_crs_rise_on_k_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crs) |-> ($past(cg_valid) && ($past(cg_data) == 5'b10001)
                      && rx_dv && (rxd == 4'b0101)));

   // data valid never without carrier
   assert_dv_inside_crs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dv |-> crs);

   // abnormal end: error without data valid means carrier just dropped
   assert_abort_drops_crs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_er && !rx_dv) |-> (!crs && $past(crs)));

   // false carrier never comes with data valid
   assert_false_cs_no_dv_R7: assert property (@(posedge clk) disable iff (!rst_n)
      false_carrier |-> !rx_dv);

   // a missing strobe freezes the level outputs and clears the pulses
   assert_gap_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cg_valid |=> ($stable(crs) && $stable(rx_dv) && $stable(rxd)
                     && !rx_er && !false_carrier));

endmodule

bind stream_delim_cs sdcs_checker u_sdcs_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .cg_valid      (cg_valid),
   .cg_data       (cg_data),
   .crs           (crs),
   .rx_dv         (rx_dv),
   .rx_er         (rx_er),
   .rxd           (rxd),
   .false_carrier (false_carrier)
);

// File: tb/stream_delim_cs_tb_top.sv
`timescale 1ns/1ps
module stream_delim_cs_tb_top;

   localparam int TAIL = 1;
   localparam logic [4:0] C_J = 5'b11000;
   localparam logic [4:0] C_K = 5'b10001;
   localparam logic [4:0] C_T = 5'b01101;
   localparam logic [4:0] C_R = 5'b00111;
   localparam logic [4:0] C_I = 5'b11111;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cg_valid = 1'b0;
   logic [4:0] cg_data = 5'b0;
   logic       crs, rx_dv, rx_er, false_carrier;
   logic [3:0] rxd;

   always #10 clk = ~clk;

   stream_delim_cs #(.CRS_TAIL(TAIL)) dut_i (
      .clk(clk), .rst_n(rst_n), .cg_valid(cg_valid), .cg_data(cg_data),
      .crs(crs), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
      .false_carrier(false_carrier)
   );

   int    n_tests = 0;
   int    n_fail  = 0;
   string tag = "R1";

   // reference model state
   int m_st = 0;      // 0 hunt, 1 after J, 2 in stream, 3 after T
   int m_tail = 0;
   int m_scrs = 0, m_dv = 0, m_rxd = 0, m_er = 0, m_fc = 0;

   function automatic int nib_of(input logic [4:0] c);
      case (c)
         5'b11110: return 0;  5'b01001: return 1;  5'b10100: return 2;
         5'b10101: return 3;  5'b01010: return 4;  5'b01011: return 5;
         5'b01110: return 6;  5'b01111: return 7;  5'b10010: return 8;
         5'b10011: return 9;  5'b10110: return 10; 5'b10111: return 11;
         5'b11010: return 12; 5'b11011: return 13; 5'b11100: return 14;
         5'b11101: return 15;
         default:  return -1;
      endcase
   endfunction

   function automatic logic [4:0] code_of(input int n);
      for (int c = 0; c < 32; c++)
         if (nib_of(5'(c)) == n) return 5'(c);
      return 5'b0;
   endfunction

   task automatic model_reset();
      m_st = 0; m_tail = 0; m_scrs = 0; m_dv = 0; m_rxd = 0; m_er = 0; m_fc = 0;
   endtask

   task automatic model_step(input logic v, input logic [4:0] c);
      int n;
      m_er = 0; m_fc = 0;
      if (!v) return;
      n = nib_of(c);
      if (m_tail > 0) m_tail--;
      case (m_st)
         0: if (c == C_J) m_st = 1;
         1: if (c == C_K) begin
               m_st = 2; m_scrs = 1; m_dv = 1; m_rxd = 5; m_tail = 0;
            end else begin
               m_st = 0; m_fc = 1;
            end
         2: if (n >= 0) begin
               m_dv = 1; m_rxd = n;
            end else if (c == C_T) begin
               m_st = 3; m_dv = 0; m_rxd = 0;
            end else if (c == C_I) begin
               m_st = 0; m_scrs = 0; m_dv = 0; m_rxd = 0; m_er = 1;
            end else begin
               m_dv = 1; m_rxd = 0; m_er = 1;
            end
         default: begin
            m_st = 0; m_scrs = 0;
            if (c == C_R) m_tail = TAIL; else m_er = 1;
         end
      endcase
   endtask

   task automatic compare();
      logic e_crs;
      e_crs = (m_scrs != 0) || (m_tail > 0);
      n_tests++;
      if (crs !== e_crs || rx_dv !== (m_dv != 0) || rx_er !== (m_er != 0) ||
          false_carrier !== (m_fc != 0) || rxd !== 4'(m_rxd)) begin
         n_fail++;
         $display("FAIL %s: crs=%b dv=%b er=%b fc=%b rxd=%h expected crs=%b dv=%0d er=%0d fc=%0d rxd=%h",
                  tag, crs, rx_dv, rx_er, false_carrier, rxd,
                  e_crs, m_dv, m_er, m_fc, 4'(m_rxd));
      end
   endtask

   task automatic drive(input logic v, input logic [4:0] c);
      @(negedge clk);
      compare();
      cg_valid = v;
      cg_data  = c;
      if (rst_n) model_step(v, c);
   endtask

   task automatic sym(input logic [4:0] c);
      drive(1'b1, c);
   endtask

   task automatic do_reset();
      @(negedge clk);
      compare();
      rst_n = 1'b0;
      cg_valid = 1'b0;
      model_reset();
      repeat (3) drive(1'b0, 5'b0);
      @(negedge clk);
      compare();
      rst_n = 1'b1;
      model_step(1'b0, 5'b0);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=done");
      finish_run();
   end

   initial begin : stim
      model_reset();
      // R1: reset state
      tag = "R1";
      repeat (3) drive(1'b0, 5'b0);
      @(negedge clk); compare(); rst_n = 1'b1; model_step(1'b0, 5'b0);
      drive(1'b0, 5'b0);

      // R9: idle traffic, no J
      tag = "R9";
      repeat (4) sym(C_I);
      sym(C_K); sym(C_T); sym(C_R); sym(code_of(3)); sym(C_I);

      // R2 / R3 / R4: full normal frame with every nibble
      tag = "R2"; sym(C_J); sym(C_K);
      tag = "R3";
      for (int i = 0; i < 16; i++) sym(code_of(i));
      tag = "R4"; sym(C_T); sym(C_R); sym(C_I); sym(C_I); sym(C_I);

      // R5: idle inside stream, then idle after T
      tag = "R5";
      sym(C_J); sym(C_K); sym(code_of(9)); sym(C_I); sym(C_I);
      sym(C_J); sym(C_K); sym(code_of(2)); sym(C_T); sym(C_I); sym(C_I);
      sym(C_J); sym(C_K); sym(C_T); sym(code_of(7)); sym(C_I);

      // R6: bad codes inside stream
      tag = "R6";
      sym(C_J); sym(C_K); sym(5'b00000); sym(code_of(4)); sym(C_J);
      sym(C_R); sym(C_K); sym(5'b00001); sym(code_of(10)); sym(C_T); sym(C_R); sym(C_I);

      // R7: false carrier, J J K does not start a stream
      tag = "R7";
      sym(C_J); sym(C_I); sym(C_I);
      sym(C_J); sym(C_J); sym(C_K); sym(code_of(1)); sym(C_I);
      sym(C_J); sym(code_of(5)); sym(C_I);

      // R8: strobe gaps between delimiter halves and inside data
      tag = "R8";
      sym(C_J); drive(1'b0, C_I); drive(1'b0, C_J); sym(C_K);
      drive(1'b0, C_I); sym(code_of(12)); drive(1'b0, C_T);
      sym(C_T); drive(1'b0, C_I); sym(C_R); drive(1'b0, C_I); drive(1'b0, C_I);
      sym(C_I); sym(C_I);

      // R4: new stream starting right after end while tail runs
      tag = "R4";
      sym(C_J); sym(C_K); sym(code_of(6)); sym(C_T); sym(C_R);
      sym(C_J); sym(C_K); sym(code_of(8)); sym(C_I); sym(C_I);

      // R1: reset in the middle of a stream
      tag = "R1";
      sym(C_J); sym(C_K); sym(code_of(11));
      do_reset();
      drive(1'b0, 5'b0); sym(code_of(2)); sym(C_I);

      // R3: random frames with gaps, bad codes and all endings
      tag = "R3";
      for (int f = 0; f < 250; f++) begin
         int len;
         if ($urandom_range(0, 9) == 0) sym(C_J);
         sym(C_J);
         if ($urandom_range(0, 7) == 0) drive(1'b0, C_K);
         sym(($urandom_range(0, 9) == 0) ? C_T : C_K);
         len = $urandom_range(1, 20);
         for (int k = 0; k < len; k++) begin
            int r = $urandom_range(0, 99);
            if (r < 6)       drive(1'b0, 5'($urandom_range(0, 31)));
            else if (r < 10) sym(5'($urandom_range(0, 31)));
            else             sym(code_of($urandom_range(0, 15)));
         end
         case ($urandom_range(0, 3))
            0: sym(C_I);
            1: begin sym(C_T); sym(C_I); end
            default: begin sym(C_T); sym(C_R); end
         endcase
         repeat ($urandom_range(0, 3)) sym(C_I);
      end
      drive(1'b0, 5'b0);
      finish_run();
   end

endmodule